// File: doc/BRIEF.md
# Digital Gain and Offset Stage

This block stretches a chosen slice of a 12-bit pixel's dynamic range. It multiplies each incoming pixel by a programmable gain and then adds a signed offset. The result is clamped to the legal pixel range and sent downstream with a matching valid strobe. The gain law is `1 + code/8`, with an 8-bit code. Code 0 gives unity gain, each step adds 0.125, and code 255 gives x32.875. The offset is a 13-bit two's-complement value in steps of one LSB.

A 2-bit control field chooses which of the two operations are active. With both bits clear the stage is a pure delay line. The gain code, offset code and control field are quasi-static settings. They are sampled together with each pixel, so a change made between two pixels applies cleanly to the later pixel. The stage is fully pipelined. It accepts a pixel on every clock and produces the result two clocks later.

Top module: `pix_gain_offset`

## Requirements
- R1: While reset is asserted, and on the first clock after it is released, `out_valid` is 0 and `out_pixel` is 0.
- R2: `out_valid` rises exactly two clock edges after the edge that samples `in_valid` high. One result is produced per accepted pixel, in order, with no gaps inserted.
- R3: With `proc_ctrl[0]` = 1, the gain result is floor(pixel × (8 + `gain_code`) / 8). Code 0 leaves the pixel unchanged, code 8 doubles it, and code 255 scales it by 263/8.
- R4: With `proc_ctrl[1]` = 1, `ofs_code` is read as a 13-bit two's-complement number in the range −4096..+4095 and is added to the (gained) pixel. For example, 13'h1FFF is −1 and 13'h1000 is −4096.
- R5: With both bits set, the gain is applied first and the offset is added to the full-precision gained value. Nothing is clamped between the two operations.
- R6: A final result above 4095 is output as 4095.
- R7: A final result below 0 is output as 0.
- R8: With `proc_ctrl` = 2'b00, `out_pixel` equals the input pixel, whatever the gain and offset codes are.
- R9: The gain code has no effect when `proc_ctrl[0]` = 0. The offset code has no effect when `proc_ctrl[1]` = 0.
- R10: When `out_valid` is 0, `out_pixel` keeps the last value it presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| gain_code | input | 8 | Gain setting; gain = 1 + code/8 |
| ofs_code | input | 13 | Signed offset, two's complement |
| proc_ctrl | input | 2 | Bit 0 enables the gain, bit 1 enables the offset |
| in_valid | input | 1 | Input pixel qualifier |
| in_pixel | input | 12 | Input pixel |
| out_valid | output | 1 | Output pixel qualifier |
| out_pixel | output | 12 | Adjusted, clamped pixel |

## Verification
In one cycle the gain can push the intermediate value far above 4095 while a negative offset pulls it back. The stage must not clamp before the offset is added. The bench provokes this by pairing large gains with large negative offsets, for example 1500 at x3 with −1000, which must give 3500. It also pairs small gains with offsets large enough to swing the sum below zero, and it runs a mixed back-to-back stream in which saturation, clipping and pass-through alternate from one pixel to the next. A scoreboard built from the arithmetic in the requirements judges every result, including its arrival cycle.

// File: rtl/gof_pkg.sv
package gof_pkg;

  typedef struct packed {
    logic gain_en;
    logic ofs_en;
  } gof_ctrl_t;

  // Field layout: bit 0 enables the gain, bit 1 enables the offset.
  function automatic gof_ctrl_t decode_ctrl(input logic [1:0] field);
    gof_ctrl_t c;
    c.gain_en = field[0];
    c.ofs_en  = field[1];
    return c;
  endfunction

endpackage

// File: rtl/gof_scale.sv
module gof_scale
  import gof_pkg::*;
#(
  parameter int PIX_W    = 12,
  parameter int GAIN_W   = 8,
  parameter int FRAC_W   = 3,
  parameter int OFS_W    = 13,
  parameter int SCALED_W = 18
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  input  logic [PIX_W-1:0]    in_pixel,
  input  logic [GAIN_W-1:0]   gain_code,
  input  logic [OFS_W-1:0]    ofs_code,
  input  logic [1:0]          proc_ctrl,
  output logic                s1_valid,
  output logic [SCALED_W-1:0] s1_scaled,
  output logic [OFS_W-1:0]    s1_ofs
);

  localparam int MULT_W = GAIN_W + 1;
  localparam int PROD_W = PIX_W + MULT_W;
  localparam int UNITY  = 1 << FRAC_W;

  gof_ctrl_t             ctl;
  logic [MULT_W-1:0]     mult;
  logic [PROD_W-1:0]     prod;
  logic [SCALED_W-1:0]   scaled_d;
  logic [OFS_W-1:0]      ofs_d;

  always_comb begin
    ctl      = decode_ctrl(proc_ctrl);
    mult     = MULT_W'(UNITY) + MULT_W'(gain_code);
    prod     = PROD_W'(in_pixel) * PROD_W'(mult);
    scaled_d = ctl.gain_en ? prod[PROD_W-1:FRAC_W] : SCALED_W'(in_pixel);
    ofs_d    = ctl.ofs_en ? ofs_code : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid  <= 1'b0;
      s1_scaled <= '0;
      s1_ofs    <= '0;
    end else begin
      s1_valid <= in_valid;
      if (in_valid) begin
        s1_scaled <= scaled_d;
        s1_ofs    <= ofs_d;
      end
    end
  end

endmodule

// File: rtl/gof_clamp.sv
module gof_clamp #(
  parameter int PIX_W    = 12,
  parameter int OFS_W    = 13,
  parameter int SCALED_W = 18,
  parameter int SUM_W    = 20
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                s1_valid,
  input  logic [SCALED_W-1:0] s1_scaled,
  input  logic [OFS_W-1:0]    s1_ofs,
  output logic                out_valid,
  output logic [PIX_W-1:0]    out_pixel
);

  localparam int MAXV = (1 << PIX_W) - 1;

  logic [SUM_W-1:0] sum;
  logic             neg;
  logic             over;
  logic [PIX_W-1:0] sat;

  always_comb begin
    sum  = {{(SUM_W-SCALED_W){1'b0}}, s1_scaled}
         + {{(SUM_W-OFS_W){s1_ofs[OFS_W-1]}}, s1_ofs};
    neg  = sum[SUM_W-1];
    over = !neg && (sum > SUM_W'(MAXV));
    if (neg)       sat = '0;
    else if (over) sat = '1;
    else           sat = sum[PIX_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_pixel <= '0;
    end else begin
      out_valid <= s1_valid;
      if (s1_valid) out_pixel <= sat;
    end
  end

endmodule

// File: rtl/pix_gain_offset.sv
module pix_gain_offset #(
  parameter int PIX_W  = 12,
  parameter int GAIN_W = 8,
  parameter int FRAC_W = 3,
  parameter int OFS_W  = 13
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [GAIN_W-1:0] gain_code,
  input  logic [OFS_W-1:0]  ofs_code,
  input  logic [1:0]        proc_ctrl,
  input  logic              in_valid,
  input  logic [PIX_W-1:0]  in_pixel,
  output logic              out_valid,
  output logic [PIX_W-1:0]  out_pixel
);

  localparam int MULT_W   = GAIN_W + 1;
  localparam int PROD_W   = PIX_W + MULT_W;
  localparam int SCALED_W = PROD_W - FRAC_W;
  localparam int SUM_W    = ((SCALED_W > OFS_W) ? SCALED_W : OFS_W) + 2;

  logic                s1_valid;
  logic [SCALED_W-1:0] s1_scaled;
  logic [OFS_W-1:0]    s1_ofs;

  gof_scale #(
    .PIX_W(PIX_W), .GAIN_W(GAIN_W), .FRAC_W(FRAC_W),
    .OFS_W(OFS_W), .SCALED_W(SCALED_W)
  ) u_scale (
    .clk(clk), .rst(rst),
    .in_valid(in_valid), .in_pixel(in_pixel),
    .gain_code(gain_code), .ofs_code(ofs_code), .proc_ctrl(proc_ctrl),
    .s1_valid(s1_valid), .s1_scaled(s1_scaled), .s1_ofs(s1_ofs)
  );

  gof_clamp #(
    .PIX_W(PIX_W), .OFS_W(OFS_W), .SCALED_W(SCALED_W), .SUM_W(SUM_W)
  ) u_clamp (
    .clk(clk), .rst(rst),
    .s1_valid(s1_valid), .s1_scaled(s1_scaled), .s1_ofs(s1_ofs),
    .out_valid(out_valid), .out_pixel(out_pixel)
  );

endmodule

// File: rtl/gof_chk.sv
module gof_chk #(
  parameter int PIX_W = 12
) (
  input logic             clk,
  input logic             rst,
  input logic [1:0]       proc_ctrl,
  input logic             in_valid,
  input logic [PIX_W-1:0] in_pixel,
  input logic             out_valid,
  input logic [PIX_W-1:0] out_pixel
);

  logic [1:0] warm;

  always_ff @(posedge clk) begin
    if (rst)              warm <= 2'd0;
    else if (warm != 2'd2) warm <= warm + 2'd1;
  end

  AST_RESET_STATE: assert property (@(posedge clk) disable iff (rst)
    (warm == 2'd0) |-> (!out_valid && out_pixel == '0)); // R1

  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (rst)
    (warm == 2'd2) |-> (out_valid == $past(in_valid, 2))); // R2

  AST_BYPASS_EXACT: assert property (@(posedge clk) disable iff (rst)
    (warm == 2'd2 && $past(in_valid, 2) && $past(proc_ctrl, 2) == 2'b00)
      |-> (out_pixel == $past(in_pixel, 2))); // R8

  AST_ZERO_STAYS_ZERO: assert property (@(posedge clk) disable iff (rst)
    (warm == 2'd2 && $past(in_valid, 2) && $past(in_pixel, 2) == '0
      && !$past(proc_ctrl[1], 2)) |-> (out_pixel == '0)); // R3

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (warm != 2'd0 && !out_valid) |-> $stable(out_pixel)); // R10

endmodule

bind pix_gain_offset gof_chk #(.PIX_W(PIX_W)) u_chk (
  .clk(clk), .rst(rst), .proc_ctrl(proc_ctrl),
  .in_valid(in_valid), .in_pixel(in_pixel),
  .out_valid(out_valid), .out_pixel(out_pixel)
);

// File: tb/pix_gain_offset_tb.sv
`timescale 1ns/1ps
module pix_gain_offset_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  gain_code = '0;
  logic [12:0] ofs_code = '0;
  logic [1:0]  proc_ctrl = '0;
  logic        in_valid = 1'b0;
  logic [11:0] in_pixel = '0;
  logic        out_valid;
  logic [11:0] out_pixel;

  int checks = 0;
  int errors = 0;
  int cycle = 0;
  int last_exp = 0;
  bit done = 0;

  int    exp_q[$];
  int    cyc_q[$];
  string tag_q[$];

  always #2 clk = ~clk;
  always @(posedge clk) cycle <= cycle + 1;

  pix_gain_offset u_dut (
    .clk(clk), .rst(rst), .gain_code(gain_code), .ofs_code(ofs_code),
    .proc_ctrl(proc_ctrl), .in_valid(in_valid), .in_pixel(in_pixel),
    .out_valid(out_valid), .out_pixel(out_pixel)
  );

  function automatic int model(int pix, int g, int ofs, int ctrl);
    int v;
    v = (ctrl & 1) ? (pix * (8 + g)) / 8 : pix;
    if (ctrl & 2) v = v + ofs;
    if (v > 4095) v = 4095;
    if (v < 0) v = 0;
    return v;
  endfunction

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic send(string tag, int pix, int g, int ofs, int ctrl);
    @(negedge clk);
    in_pixel  = 12'(pix);
    gain_code = 8'(g);
    ofs_code  = 13'(ofs);
    proc_ctrl = 2'(ctrl);
    in_valid  = 1'b1;
    last_exp  = model(pix, g, ofs, ctrl);
    exp_q.push_back(last_exp);
    cyc_q.push_back(cycle);
    tag_q.push_back(tag);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      gain_code = 8'hA5;
      ofs_code = 13'h0F0F;
    end
  endtask

  // Monitor: scoreboard pop, value and arrival-cycle compare
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      if (exp_q.size() == 0) begin
        check("R2 unexpected out_valid", 1, 0);
      end else begin
        int e, c;
        string t;
        e = exp_q.pop_front();
        c = cyc_q.pop_front();
        t = tag_q.pop_front();
        check(t, int'(out_pixel), e);
        check({t, " R2 latency"}, cycle - c, 2);
      end
    end
  end

  initial begin
    #400000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    check("R1 reset out_valid", int'(out_valid), 0);
    check("R1 reset out_pixel", int'(out_pixel), 0);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 post-reset out_valid", int'(out_valid), 0);
    check("R1 post-reset out_pixel", int'(out_pixel), 0);

    // Bypass: codes present but disabled
    send("R8 bypass", 1234, 255, 100, 0);
    send("R8 bypass max", 4095, 255, 4095, 0);
    send("R9 gain ignored under offset-only", 500, 200, 7, 2);
    send("R9 offset ignored under gain-only", 500, 8, -4096, 1);
    idle(3);

    // Gain law
    send("R3 unity code0", 3000, 0, 0, 1);
    send("R3 double code8", 1000, 8, 0, 1);
    send("R3 code255 floor", 100, 255, 0, 1);
    send("R3 fraction floor", 7, 3, 0, 1);
    send("R6 gain saturates", 4095, 255, 0, 1);
    idle(2);

    // Offset
    send("R4 offset minus one", 2000, 0, -1, 2);
    send("R4 offset max positive", 0, 0, 4095, 2);
    send("R6 offset saturates", 100, 0, 4095, 2);
    send("R7 offset clips at -4096", 2000, 0, -4096, 2);
    idle(2);

    // Gain then offset in the same cycle
    send("R5 overrange pulled back", 1500, 16, -1000, 3);
    send("R5 R6 still saturated", 4095, 255, -4096, 3);
    send("R5 R7 swings negative", 200, 16, -4096, 3);
    send("R5 both mid", 333, 5, 77, 3);

    // Back-to-back mixed stream
    for (int i = 0; i < 60; i++) begin
      send("R2 R5 mixed stream", (i * 389 + 17) % 4096, (i * 37) % 256,
           ((i * 1231) % 8192) - 4096, i % 4);
    end
    idle(6);
    check("R10 hold after drain", int'(out_pixel), last_exp);
    check("R10 queue drained", exp_q.size(), 0);
    idle(5);
    check("R10 hold while idle", int'(out_pixel), last_exp);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule